// File: doc/BRIEF.md
# Program clock reference counter

This block keeps the free-running 42-bit program clock of a transport-stream multiplexer. A 27 MHz enable steps a 9-bit fine field that counts modulo 300. Every wrap of that fine field advances a 33-bit coarse field, so the coarse field ticks at 90 kHz. The coarse field itself wraps to zero after about 26.5 hours.

The combined value is presented on one output for a packetizer to sample. Both fields can be loaded together in one cycle. A one-cycle insertion strobe marks when the next clock-reference sample should be carried in a packet. The spacing of the strobe is set in coarse ticks; the default is 9000 ticks, which is 100 ms. A snapshot register captures both fields on the same edge, so a reader never sees a half-finished rollover.

Top module: `pcr_counter`

## Requirements
- R1: After a synchronous reset, `pcr_value`, `snap_value` and `insert_strobe` are all zero.
- R2: On each clock with `tick_en` high and `load` low, the fine field (bits 8:0 of `pcr_value`) rises by one. From 299 it returns to 0, so it never holds 300 to 511.
- R3: The coarse field (bits 41:9 of `pcr_value`) rises by exactly one on the same edge where the fine field wraps from 299 to 0. From 0x1FFFFFFFF it wraps to 0.
- R4: `pcr_value` is the coarse field concatenated above the fine field, with the coarse field in bits 41:9 and the fine field in bits 8:0.
- R5: While `tick_en` is low and `load` is low, both fields hold their values and the insertion interval count does not move.
- R6: `load` takes priority over `tick_en`. On the next cycle the coarse field equals `load_base`, and the fine field equals `load_ext`, or 299 when `load_ext` is 300 or more. The insertion interval count is cleared.
- R7: `insert_strobe` is high for exactly one cycle. That cycle is the one right after the coarse increment that completes the interval since the last strobe, load or reset. The interval is `ivl_cfg` coarse increments; if the count already stands at or past the interval, the next increment ends it.
- R8: An `ivl_cfg` of zero selects the parameter `IVL_DEFAULT`, which is 9000 unless overridden.
- R9: One cycle after `snap_req` is high, `snap_value` equals the `pcr_value` present at that edge. Without `snap_req`, `snap_value` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 27 MHz step enable |
| load | input | 1 | Load both fields this cycle |
| load_base | input | 33 | Coarse value to load |
| load_ext | input | 9 | Fine value to load (clamped to 299) |
| ivl_cfg | input | 16 | Insertion interval in coarse ticks, 0 selects the default |
| snap_req | input | 1 | Capture the current value into the snapshot |
| pcr_value | output | 42 | Live combined value, coarse in 41:9 and fine in 8:0 |
| snap_value | output | 42 | Captured combined value |
| insert_strobe | output | 1 | One-cycle insertion marker |

## Verification
Every result here is registered. The fields, the clamped load, the snapshot and the strobe all become visible one clock after the edge that caused them. No result needs a second cycle. The bench drives inputs at the falling edge and steps a bench model at the rising edge. It then compares all three outputs at the next falling edge, so each check lands exactly one register stage after its stimulus. A second instance, with its default interval overridden to 4, checks the zero-selects-default path. Its strobe is expected one cycle after every 1200th enabled edge.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int PCR_EXT_W  = 9;
  localparam int PCR_EXT_M  = 300;
  localparam int PCR_BASE_W = 33;
  localparam int PCR_IVL_W  = 16;
  localparam int PCR_IVL_DF = 9000;
endpackage

// File: rtl/pcr_ext_div.sv
module pcr_ext_div #(
  parameter int EXT_W   = pcr_pkg::PCR_EXT_W,
  parameter int EXT_MOD = pcr_pkg::PCR_EXT_M
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load,
  input  logic [EXT_W-1:0] load_val,
  output logic [EXT_W-1:0] ext_q,
  output logic             carry
);
  localparam logic [EXT_W-1:0] LAST = EXT_W'(EXT_MOD - 1);

  logic [EXT_W-1:0] load_cl;
  assign load_cl = (load_val > LAST) ? LAST : load_val;
  assign carry   = tick_en && !load && (ext_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)            ext_q <= '0;
    else if (load)      ext_q <= load_cl;
    else if (tick_en)   ext_q <= (ext_q == LAST) ? '0 : ext_q + 1'b1;
  end

  p_ext_range_r2: assert property (@(posedge clk) disable iff (rst)
    ext_q <= LAST);
  p_ext_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !load && ext_q == LAST) |=> ext_q == '0);
  p_ext_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load) |=> $stable(ext_q));
  p_ext_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (load && load_val > LAST) |=> ext_q == LAST);
endmodule

// File: rtl/pcr_base_cnt.sv
module pcr_base_cnt #(
  parameter int BASE_W = pcr_pkg::PCR_BASE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [BASE_W-1:0] load_val,
  output logic [BASE_W-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)         base_q <= '0;
    else if (load)   base_q <= load_val;
    else if (step)   base_q <= base_q + 1'b1;
  end

  p_base_step_r3: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> base_q == $past(base_q) + 1'b1);
  p_base_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(base_q));
endmodule

// File: rtl/pcr_ins_timer.sv
module pcr_ins_timer #(
  parameter int IVL_W       = pcr_pkg::PCR_IVL_W,
  parameter int IVL_DEFAULT = pcr_pkg::PCR_IVL_DF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [IVL_W-1:0] ivl_cfg,
  output logic             strobe
);
  logic [IVL_W-1:0] icnt;
  logic [IVL_W-1:0] ivl_eff;
  logic             done;

  assign ivl_eff = (ivl_cfg == '0) ? IVL_W'(IVL_DEFAULT) : ivl_cfg;
  assign done    = (icnt >= ivl_eff - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || load) begin
      icnt   <= '0;
      strobe <= 1'b0;
    end else if (step) begin
      icnt   <= done ? '0 : icnt + 1'b1;
      strobe <= done;
    end else begin
      strobe <= 1'b0;
    end
  end

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(icnt));
endmodule

// File: rtl/pcr_counter.sv
module pcr_counter #(
  parameter int EXT_W       = pcr_pkg::PCR_EXT_W,
  parameter int EXT_MOD     = pcr_pkg::PCR_EXT_M,
  parameter int BASE_W      = pcr_pkg::PCR_BASE_W,
  parameter int IVL_W       = pcr_pkg::PCR_IVL_W,
  parameter int IVL_DEFAULT = pcr_pkg::PCR_IVL_DF,
  localparam int PCR_W      = BASE_W + EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              load,
  input  logic [BASE_W-1:0] load_base,
  input  logic [EXT_W-1:0]  load_ext,
  input  logic [IVL_W-1:0]  ivl_cfg,
  input  logic              snap_req,
  output logic [PCR_W-1:0]  pcr_value,
  output logic [PCR_W-1:0]  snap_value,
  output logic              insert_strobe
);
  logic [EXT_W-1:0]  ext_q;
  logic [BASE_W-1:0] base_q;
  logic              carry;

  pcr_ext_div #(.EXT_W(EXT_W), .EXT_MOD(EXT_MOD)) u_ext (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load(load),
    .load_val(load_ext), .ext_q(ext_q), .carry(carry));

  pcr_base_cnt #(.BASE_W(BASE_W)) u_base (
    .clk(clk), .rst(rst), .step(carry), .load(load),
    .load_val(load_base), .base_q(base_q));

  pcr_ins_timer #(.IVL_W(IVL_W), .IVL_DEFAULT(IVL_DEFAULT)) u_ins (
    .clk(clk), .rst(rst), .step(carry), .load(load),
    .ivl_cfg(ivl_cfg), .strobe(insert_strobe));

  assign pcr_value = {base_q, ext_q};

  always_ff @(posedge clk) begin
    if (rst)           snap_value <= '0;
    else if (snap_req) snap_value <= pcr_value;
  end

  p_snap_capture_r9: assert property (@(posedge clk) disable iff (rst)
    snap_req |=> snap_value == $past(pcr_value));
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(snap_value));
endmodule

// File: tb/pcr_counter_test.sv
module pcr_counter_test;
  localparam logic [8:0] LAST = 9'd299;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, load = 1'b0, snap_req = 1'b0;
  logic [32:0] load_base = '0;
  logic [8:0]  load_ext = '0;
  logic [15:0] ivl_cfg = 16'd2;
  logic [41:0] pcr_value, snap_value, d_pcr, d_snap;
  logic        insert_strobe, d_strobe;

  int checks = 0, fails = 0, ncyc = 0;
  bit done = 1'b0;

  // model state
  logic [32:0] m_base = '0;
  logic [8:0]  m_ext = '0;
  logic [15:0] m_icnt = '0;
  logic        m_strobe = 1'b0;
  logic [41:0] m_snap = '0;
  int          d_edges = 0;

  always #5 clk = ~clk;

  pcr_counter uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .load(load),
    .load_base(load_base), .load_ext(load_ext), .ivl_cfg(ivl_cfg),
    .snap_req(snap_req), .pcr_value(pcr_value), .snap_value(snap_value),
    .insert_strobe(insert_strobe));

  pcr_counter #(.IVL_DEFAULT(4)) uut_dflt (
    .clk(clk), .rst(rst), .tick_en(1'b1), .load(1'b0),
    .load_base(33'd0), .load_ext(9'd0), .ivl_cfg(16'd0),
    .snap_req(1'b0), .pcr_value(d_pcr), .snap_value(d_snap),
    .insert_strobe(d_strobe));

  function automatic logic [8:0] clamp_ext(input logic [8:0] v);
    return (v > LAST) ? LAST : v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, ncyc);
    end
  endtask

  task automatic model_step();
    logic [15:0] ivl;
    ivl = (ivl_cfg == 16'd0) ? 16'd9000 : ivl_cfg;
    if (snap_req) m_snap = {m_base, m_ext};
    if (load) begin
      m_base = load_base; m_ext = clamp_ext(load_ext); m_icnt = '0; m_strobe = 1'b0;
    end else if (tick_en) begin
      m_strobe = 1'b0;
      if (m_ext == LAST) begin
        m_ext = '0; m_base = m_base + 1'b1;
        if (m_icnt >= ivl - 1'b1) begin m_icnt = '0; m_strobe = 1'b1; end
        else m_icnt = m_icnt + 1'b1;
      end else m_ext = m_ext + 1'b1;
    end else m_strobe = 1'b0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R4 pcr_value"}, 64'(pcr_value), 64'({m_base, m_ext}));
    chk({tag, " R7 insert_strobe"}, 64'(insert_strobe), 64'(m_strobe));
    chk({tag, " R9 snap_value"}, 64'(snap_value), 64'(m_snap));
    chk("R8 default interval strobe", 64'(d_strobe),
        64'(d_edges > 0 && d_edges % 1200 == 0));
    chk("R2 default-instance fine field", 64'(d_pcr[8:0]), 64'(d_edges % 300));
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    d_edges++;
    ncyc++;
    @(negedge clk);
    check_all(tag);
    load = 1'b0; snap_req = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pcr", 64'(pcr_value), 64'd0);
    chk("R1 reset snap", 64'(snap_value), 64'd0);
    chk("R1 reset strobe", 64'(insert_strobe), 64'd0);
    rst = 1'b0;

    // R2/R3/R7: steady count across several rollovers
    tick_en = 1'b1;
    repeat (2000) cyc("steady R2 R3");

    // R5: hold with enable low
    tick_en = 1'b0;
    repeat (50) cyc("hold R5");

    // R3: coarse wrap at maximum, with R6 load
    load = 1'b1; load_base = 33'h1FFFFFFFF; load_ext = 9'd297;
    cyc("load R6");
    tick_en = 1'b1;
    snap_req = 1'b1;
    repeat (6) cyc("wrap R3");

    // R6: clamp of out-of-range fine value, load over tick
    load = 1'b1; load_base = 33'h12345; load_ext = 9'd511;
    cyc("clamp R6");
    load = 1'b1; load_ext = 9'd300;
    cyc("clamp R6 300");

    // R9: snapshot on the rollover edge
    load = 1'b1; load_ext = 9'd298; cyc("load R6");
    snap_req = 1'b1; cyc("snap R9");
    snap_req = 1'b1; cyc("snap rollover R9");

    // random mix
    for (int i = 0; i < 30000; i++) begin
      tick_en  = ($urandom % 4) != 0;
      snap_req = ($urandom % 16) == 0;
      if (($urandom % 700) == 0) begin
        load = 1'b1;
        load_base = ($urandom % 2) ? 33'h1FFFFFFFF - 33'($urandom % 3) : {1'b0, 32'($urandom)};
        load_ext = 9'($urandom);
      end
      if (($urandom % 3000) == 0) ivl_cfg = 16'(1 + $urandom % 3);
      cyc("random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule